// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block is the per-processor acceptance and prioritisation core of a local interrupt controller. It keeps three 256-entry bit vectors: pending requests, vectors in service, and the trigger mode of each vector. Interrupts arrive one per cycle as an 8-bit vector plus a level/edge flag. A task-priority value and a 16-bit configuration word set its behaviour. The configuration word holds an enable bit, a directed-completion bit and the spurious vector.

The processor sees one request line. It answers with an acknowledge strobe, and one cycle later it receives either a vector, the spurious vector or a "nothing pending" flag. When a handler finishes, an end-of-interrupt strobe retires the most urgent in-service vector. If that vector was level-triggered, the block emits a completion broadcast so that the interrupt source can re-arm. When nothing here is deliverable, a legacy interrupt line may be passed through in place of the normal request.

Top module: `lapic_prio_core`

## Requirements
- R1: When configuration bit 8 is 0, `cpu_irq` and `legacy_fwd` stay low and an acknowledge answers with `ack_none`=1.
- R2: When no request is pending, `cpu_irq` is low and an acknowledge answers with `ack_none`=1.
- R3: The candidate is the pending vector with the highest number. Among several pending vectors, the highest number is granted first.
- R4: Processor priority is computed from the task priority and the highest in-service vector. It equals the task priority when the task priority's upper nibble is greater than or equal to that vector's upper nibble. Otherwise it equals that vector with its lower nibble cleared. A candidate is masked when the processor priority is nonzero and the candidate's upper nibble is less than or equal to the processor priority's upper nibble. A masked candidate does not raise `cpu_irq`.
- R5: An acknowledge made while the only candidate is masked answers with `ack_none`=0 and `ack_vec` equal to configuration bits 7:0. The pending and in-service vectors are left as they were.
- R6: An acknowledge with a deliverable candidate answers with that vector in the cycle after the strobe. It also moves the vector from pending to in service.
- R7: An incoming interrupt marks its vector pending. It records level trigger when `in_level`=1 and edge trigger when `in_level`=0, and a later arrival overwrites the earlier record.
- R8: End-of-interrupt retires the highest-numbered in-service vector. If that vector was level-triggered, `bc_valid` pulses for one cycle, one cycle after the strobe, with `bc_vec` set to that vector.
- R9: While configuration bit 12 is 1, end-of-interrupt still retires the vector but produces no broadcast.
- R10: End-of-interrupt with nothing in service changes no state and produces no broadcast.
- R11: `legacy_fwd` is high exactly when the block is enabled, no candidate is deliverable, `legacy_ok` is 1 and `legacy_req` is 1. `cpu_irq` and `legacy_fwd` are never high together.
- R12: After every acknowledge and every end-of-interrupt, `cpu_irq` reflects the updated vectors from the cycle after the strobe.
- R13: Acknowledge and end-of-interrupt in the same cycle are both judged on the state before the clock edge, and both take effect. An incoming interrupt that names the vector being acknowledged leaves that vector pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming interrupt strobe |
| in_vec | input | 8 | Incoming interrupt vector |
| in_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr | input | 8 | Task priority |
| sv_cfg | input | 16 | Bit 8 enable, bit 12 suppress broadcast, bits 7:0 spurious vector |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| legacy_ok | input | 1 | Legacy pass-through accepted |
| legacy_req | input | 1 | Legacy controller output |
| cpu_irq | output | 1 | Interrupt request to the processor |
| legacy_fwd | output | 1 | Forwarded legacy interrupt |
| ack_rsp | output | 1 | Acknowledge response valid (one cycle after `ack`) |
| ack_none | output | 1 | Response is "no interrupt" |
| ack_vec | output | 8 | Granted or spurious vector |
| bc_valid | output | 1 | Completion broadcast pulse |
| bc_vec | output | 8 | Completed level-triggered vector |

## Verification
The acknowledge and the end-of-interrupt can land in the same cycle, and both touch the in-service vector. To provoke this, the bench puts a level-triggered low vector in service and leaves a higher edge-triggered vector pending, then raises both strobes together. In the next cycle the response must carry the higher vector and the broadcast must carry the lower one. Follow-up end-of-interrupts then show that only the higher vector is left in service. A second collision drives an incoming interrupt for the very vector being acknowledged, and the request line must show that the vector is still pending.

// File: rtl/lapic_pkg.sv
package lapic_pkg;

  localparam int VEC_W   = 8;
  localparam int CLS_W   = 4;
  localparam int CFG_W   = 16;
  localparam int EN_BIT  = 8;
  localparam int DIR_BIT = 12;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_TAKE = 2'd2
  } ack_kind_e;

  // priority class of a vector (upper nibble)
  function automatic logic [CLS_W-1:0] prio_class(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // processor priority from task priority and the top in-service vector
  function automatic vec_t proc_prio(input vec_t task_p, input logic svc_any,
                                     input vec_t svc_top);
    logic [CLS_W-1:0] svc_cls;
    svc_cls = svc_any ? prio_class(svc_top) : '0;
    if (prio_class(task_p) >= svc_cls)
      return task_p;
    return {svc_cls, {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // candidate held back by processor priority
  function automatic logic below_prio(input vec_t cand, input vec_t ppr);
    return (ppr != '0) && (prio_class(cand) <= prio_class(ppr));
  endfunction

endpackage

// File: rtl/lapic_prio_enc.sv
module lapic_prio_enc #(
  parameter int WIDTH = 256,
  parameter int GROUP = 16
) (
  input  logic [WIDTH-1:0]         req,
  output logic                     any,
  output logic [$clog2(WIDTH)-1:0] idx
);
  localparam int IW  = $clog2(WIDTH);
  localparam int GW  = $clog2(GROUP);
  localparam int NG  = WIDTH / GROUP;
  localparam int GIW = IW - GW;

  logic [NG-1:0] g_any;
  logic [GW-1:0] g_idx [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic          hit;
    logic [GW-1:0] pos;
    always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int b = 0; b < GROUP; b++) begin
        if (req[g*GROUP + b]) begin
          hit = 1'b1;
          pos = GW'(b);
        end
      end
    end
    assign g_any[g] = hit;
    assign g_idx[g] = pos;
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int g = 0; g < NG; g++) begin
      if (g_any[g]) begin
        any = 1'b1;
        idx = {GIW'(g), g_idx[g]};
      end
    end
  end

  always_comb begin
    assert_enc_hit_R3: assert (!any || req[idx]);
    assert_enc_empty_R2: assert (any || (req == '0));
  end

endmodule

// File: rtl/lapic_vec_bank.sv
module lapic_vec_bank
  import lapic_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [VW-1:0]       set_idx,
  input  logic                set_lvl,
  input  logic                take_en,
  input  logic [VW-1:0]       take_idx,
  input  logic                done_en,
  input  logic [VW-1:0]       done_idx,
  output logic [(1<<VW)-1:0]  irr,
  output logic [(1<<VW)-1:0]  isr,
  output logic [(1<<VW)-1:0]  tmr
);
  localparam int NV = 1 << VW;

  for (genvar i = 0; i < NV; i++) begin : g_bit
    localparam logic [VW-1:0] ME = VW'(i);
    logic set_me, take_me, done_me;
    assign set_me  = set_en  && (set_idx  == ME);
    assign take_me = take_en && (take_idx == ME);
    assign done_me = done_en && (done_idx == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr[i] <= 1'b0;
        isr[i] <= 1'b0;
        tmr[i] <= 1'b0;
      end else begin
        irr[i] <= (irr[i] && !take_me) || set_me;
        isr[i] <= (isr[i] && !done_me) || take_me;
        if (set_me) tmr[i] <= set_lvl;
      end
    end
  end

  assert_take_enters_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |=> isr[$past(take_idx)]);

  assert_take_leaves_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && !(set_en && set_idx == take_idx)) |=> !irr[$past(take_idx)]);

  assert_arrival_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (irr[$past(set_idx)] && (tmr[$past(set_idx)] == $past(set_lvl))));

  assert_done_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en && !(take_en && take_idx == done_idx)) |=> !isr[$past(done_idx)]);

endmodule

// File: rtl/lapic_prio_eval.sv
module lapic_prio_eval
  import lapic_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int GROUP = 16
) (
  input  logic [(1<<VW)-1:0] irr,
  input  logic [(1<<VW)-1:0] isr,
  input  logic [VW-1:0]      tpr,
  output logic               cand_any,
  output logic [VW-1:0]      cand_vec,
  output logic               svc_any,
  output logic [VW-1:0]      svc_top,
  output logic [VW-1:0]      ppr,
  output logic               masked,
  output logic               deliver
);
  localparam int NV = 1 << VW;

  lapic_prio_enc #(.WIDTH(NV), .GROUP(GROUP)) u_pend_enc (
    .req (irr),
    .any (cand_any),
    .idx (cand_vec)
  );

  lapic_prio_enc #(.WIDTH(NV), .GROUP(GROUP)) u_svc_enc (
    .req (isr),
    .any (svc_any),
    .idx (svc_top)
  );

  always_comb begin
    ppr     = proc_prio(tpr, svc_any, svc_top);
    masked  = cand_any && below_prio(cand_vec, ppr);
    deliver = cand_any && !masked;
  end

  always_comb begin
    assert_ppr_floor_R4: assert (prio_class(ppr) >= prio_class(tpr));
  end

endmodule

// File: rtl/lapic_prio_core.sv
module lapic_prio_core
  import lapic_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int GROUP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VW-1:0]    in_vec,
  input  logic             in_level,
  input  logic [VW-1:0]    tpr,
  input  logic [CFG_W-1:0] sv_cfg,
  input  logic             ack,
  input  logic             eoi,
  input  logic             legacy_ok,
  input  logic             legacy_req,
  output logic             cpu_irq,
  output logic             legacy_fwd,
  output logic             ack_rsp,
  output logic             ack_none,
  output logic [VW-1:0]    ack_vec,
  output logic             bc_valid,
  output logic [VW-1:0]    bc_vec
);
  localparam int NV = 1 << VW;

  logic [NV-1:0] irr, isr, tmr;
  logic          cand_any, svc_any, masked, deliver;
  logic [VW-1:0] cand_vec, svc_top, ppr;

  // named internal events
  logic          sw_en, dir_eoi;
  ack_kind_e     ack_kind;
  logic          take_ev, done_ev, bcast_ev;

  assign sw_en   = sv_cfg[EN_BIT];
  assign dir_eoi = sv_cfg[DIR_BIT];

  lapic_prio_eval #(.VW(VW), .GROUP(GROUP)) u_eval (
    .irr      (irr),
    .isr      (isr),
    .tpr      (tpr),
    .cand_any (cand_any),
    .cand_vec (cand_vec),
    .svc_any  (svc_any),
    .svc_top  (svc_top),
    .ppr      (ppr),
    .masked   (masked),
    .deliver  (deliver)
  );

  always_comb begin
    if (!sw_en || !cand_any) ack_kind = ACK_NONE;
    else if (masked)         ack_kind = ACK_SPUR;
    else                     ack_kind = ACK_TAKE;
  end

  assign take_ev  = ack && (ack_kind == ACK_TAKE);
  assign done_ev  = eoi && svc_any;
  assign bcast_ev = done_ev && tmr[svc_top] && !dir_eoi;

  lapic_vec_bank #(.VW(VW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (in_valid),
    .set_idx  (in_vec),
    .set_lvl  (in_level),
    .take_en  (take_ev),
    .take_idx (cand_vec),
    .done_en  (done_ev),
    .done_idx (svc_top),
    .irr      (irr),
    .isr      (isr),
    .tmr      (tmr)
  );

  assign cpu_irq    = sw_en && deliver;
  assign legacy_fwd = sw_en && !deliver && legacy_ok && legacy_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_rsp  <= 1'b0;
      ack_none <= 1'b0;
      ack_vec  <= '0;
      bc_valid <= 1'b0;
      bc_vec   <= '0;
    end else begin
      ack_rsp  <= ack;
      ack_none <= ack && (ack_kind == ACK_NONE);
      unique case (ack_kind)
        ACK_TAKE: ack_vec <= cand_vec;
        ACK_SPUR: ack_vec <= sv_cfg[VW-1:0];
        default:  ack_vec <= '0;
      endcase
      bc_valid <= bcast_ev;
      bc_vec   <= bcast_ev ? svc_top : '0;
    end
  end

  assert_off_answers_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !sw_en) |=> (ack_rsp && ack_none));

  assert_empty_answers_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cand_any) |=> ack_none);

  assert_masked_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !cpu_irq);

  assert_spur_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sw_en && masked && !in_valid && !eoi) |=> ($stable(irr) && $stable(isr)));

  assert_spur_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sw_en && masked) |=> (!ack_none && ack_vec == $past(sv_cfg[VW-1:0])));

  assert_bc_follows_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> $past(eoi));

  assert_directed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && dir_eoi) |=> !bc_valid);

  assert_idle_eoi_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !svc_any) |=> (!bc_valid && $stable(isr)));

  assert_irq_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_irq, legacy_fwd}));

  assert_ack_eoi_both_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && done_ev) |=> (ack_rsp && !ack_none));

endmodule

// File: tb/sim_lapic_prio_core.sv
module sim_lapic_prio_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_vec = '0;
  logic        in_level = 1'b0;
  logic [7:0]  tpr = '0;
  logic [15:0] sv_cfg = 16'h01FF;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic        legacy_ok = 1'b0;
  logic        legacy_req = 1'b0;
  logic        cpu_irq, legacy_fwd, ack_rsp, ack_none, bc_valid;
  logic [7:0]  ack_vec, bc_vec;

  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  lapic_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .in_level(in_level), .tpr(tpr), .sv_cfg(sv_cfg), .ack(ack), .eoi(eoi),
    .legacy_ok(legacy_ok), .legacy_req(legacy_req), .cpu_irq(cpu_irq),
    .legacy_fwd(legacy_fwd), .ack_rsp(ack_rsp), .ack_none(ack_none),
    .ack_vec(ack_vec), .bc_valid(bc_valid), .bc_vec(bc_vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock with the given strobes; outputs sampled 1 ns after the edge
  task automatic cyc(input logic iv, input logic [7:0] v, input logic lv,
                     input logic a, input logic e);
    in_valid = iv; in_vec = v; in_level = lv; ack = a; eoi = e;
    @(posedge clk); #1;
    in_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic inj(input logic [7:0] v, input logic lv);
    cyc(1'b1, v, lv, 1'b0, 1'b0);
  endtask

  task automatic do_ack(input string tag, input logic exp_none, input logic [7:0] exp_vec);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk({tag, " rsp"}, ack_rsp, 1);
    chk({tag, " none"}, ack_none, exp_none);
    if (!exp_none) chk({tag, " vec"}, ack_vec, exp_vec);
  endtask

  task automatic do_eoi(input string tag, input logic exp_bc, input logic [7:0] exp_vec);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk({tag, " bc"}, bc_valid, exp_bc);
    if (exp_bc) chk({tag, " bcvec"}, bc_vec, exp_vec);
  endtask

  task automatic t_reset;
    chk("R2 reset irq", cpu_irq, 0);
    chk("R11 reset legacy", legacy_fwd, 0);
    chk("R6 reset rsp", ack_rsp, 0);
    chk("R8 reset bc", bc_valid, 0);
  endtask

  task automatic t_empty;
    do_ack("R2 empty ack", 1'b1, 8'h00);
    chk("R2 irq low", cpu_irq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6 rsp one cycle", ack_rsp, 0);
  endtask

  task automatic t_disable;
    sv_cfg = 16'h00FF; #1;
    inj(8'h40, 1'b0);
    chk("R1 irq off", cpu_irq, 0);
    do_ack("R1 off ack", 1'b1, 8'h00);
    legacy_ok = 1'b1; legacy_req = 1'b1; #1;
    chk("R1 legacy off", legacy_fwd, 0);
    legacy_ok = 1'b0; legacy_req = 1'b0;
    sv_cfg = 16'h01FF; #1;
    chk("R1 irq on", cpu_irq, 1);
    do_ack("R6 grant", 1'b0, 8'h40);
    chk("R12 irq after ack", cpu_irq, 0);
    do_eoi("R8 edge no bc", 1'b0, 8'h00);
  endtask

  task automatic t_order;
    inj(8'h35, 1'b0); inj(8'h92, 1'b0); inj(8'h61, 1'b0);
    chk("R3 irq", cpu_irq, 1);
    do_ack("R3 first", 1'b0, 8'h92);
    chk("R4 isr masks lower", cpu_irq, 0);
    do_eoi("R12 eoi", 1'b0, 8'h00);
    chk("R12 irq back", cpu_irq, 1);
    do_ack("R3 second", 1'b0, 8'h61);
    do_eoi("R3 eoi2", 1'b0, 8'h00);
    do_ack("R3 third", 1'b0, 8'h35);
    do_eoi("R3 eoi3", 1'b0, 8'h00);
    chk("R2 drained", cpu_irq, 0);
  endtask

  task automatic t_mask;
    tpr = 8'h50; #1;
    inj(8'h55, 1'b0);
    chk("R4 tpr masks", cpu_irq, 0);
    do_ack("R5 spurious", 1'b0, 8'hFF);
    chk("R5 still masked", cpu_irq, 0);
    tpr = 8'h40; #1;
    chk("R5 irr kept", cpu_irq, 1);
    do_ack("R5 later grant", 1'b0, 8'h55);
    inj(8'h58, 1'b0);
    chk("R4 isr class masks", cpu_irq, 0);
    inj(8'h61, 1'b0);
    chk("R4 higher class", cpu_irq, 1);
    do_ack("R4 nest", 1'b0, 8'h61);
    do_eoi("R8 nest eoi1", 1'b0, 8'h00);
    chk("R4 still under 55", cpu_irq, 0);
    do_eoi("R8 nest eoi2", 1'b0, 8'h00);
    chk("R12 58 free", cpu_irq, 1);
    do_ack("R4 58", 1'b0, 8'h58);
    do_eoi("R4 58 eoi", 1'b0, 8'h00);
    tpr = 8'h00; #1;
    inj(8'h05, 1'b0);
    chk("R4 zero ppr", cpu_irq, 1);
    do_ack("R4 class0", 1'b0, 8'h05);
    do_eoi("R4 class0 eoi", 1'b0, 8'h00);
  endtask

  task automatic t_level;
    inj(8'h70, 1'b1);
    do_ack("R7 lvl ack", 1'b0, 8'h70);
    do_eoi("R8 level bc", 1'b1, 8'h70);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R8 bc pulse", bc_valid, 0);
    inj(8'h70, 1'b0);
    do_ack("R7 edge ack", 1'b0, 8'h70);
    do_eoi("R7 edge overwrites", 1'b0, 8'h00);
  endtask

  task automatic t_directed;
    sv_cfg = 16'h11FF; #1;
    inj(8'h80, 1'b1);
    do_ack("R9 ack", 1'b0, 8'h80);
    do_eoi("R9 suppressed", 1'b0, 8'h00);
    inj(8'h21, 1'b0);
    chk("R9 retired", cpu_irq, 1);
    do_ack("R9 after", 1'b0, 8'h21);
    do_eoi("R9 after eoi", 1'b0, 8'h00);
    sv_cfg = 16'h01FF; #1;
    inj(8'h30, 1'b1);
    do_ack("R8 low", 1'b0, 8'h30);
    inj(8'h90, 1'b0);
    do_ack("R8 high", 1'b0, 8'h90);
    do_eoi("R8 highest first", 1'b0, 8'h00);
    do_eoi("R8 then low", 1'b1, 8'h30);
  endtask

  task automatic t_idle_eoi;
    tpr = 8'hF0; #1;
    inj(8'h20, 1'b1);
    do_eoi("R10 idle", 1'b0, 8'h00);
    chk("R10 irq", cpu_irq, 0);
    tpr = 8'h00; #1;
    chk("R10 irr intact", cpu_irq, 1);
    do_ack("R10 ack", 1'b0, 8'h20);
    do_eoi("R10 real", 1'b1, 8'h20);
  endtask

  task automatic t_legacy;
    legacy_ok = 1'b1; legacy_req = 1'b1; #1;
    chk("R11 fwd", legacy_fwd, 1);
    chk("R11 no irq", cpu_irq, 0);
    legacy_ok = 1'b0; #1;
    chk("R11 not accepted", legacy_fwd, 0);
    legacy_ok = 1'b1; legacy_req = 1'b0; #1;
    chk("R11 no req", legacy_fwd, 0);
    legacy_req = 1'b1; #1;
    inj(8'h44, 1'b0);
    chk("R11 normal wins", legacy_fwd, 0);
    chk("R11 irq", cpu_irq, 1);
    tpr = 8'hF0; #1;
    chk("R11 masked fwd", legacy_fwd, 1);
    tpr = 8'h00; #1;
    do_ack("R11 ack", 1'b0, 8'h44);
    chk("R12 fwd after ack", legacy_fwd, 1);
    do_eoi("R11 eoi", 1'b0, 8'h00);
    legacy_ok = 1'b0; legacy_req = 1'b0; #1;
  endtask

  task automatic t_collide;
    inj(8'h30, 1'b1);
    do_ack("R13 setup", 1'b0, 8'h30);
    inj(8'h60, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R13 rsp", ack_rsp, 1);
    chk("R13 vec", ack_vec, 8'h60);
    chk("R13 bc", bc_valid, 1);
    chk("R13 bcvec", bc_vec, 8'h30);
    do_eoi("R13 60 left", 1'b0, 8'h00);
    do_eoi("R13 empty", 1'b0, 8'h00);
    inj(8'h77, 1'b0);
    cyc(1'b1, 8'h77, 1'b0, 1'b1, 1'b0);
    chk("R13 same vec", ack_vec, 8'h77);
    chk("R13 masked by self", cpu_irq, 0);
    do_eoi("R13 eoi", 1'b0, 8'h00);
    chk("R13 still pending", cpu_irq, 1);
    do_ack("R13 reack", 1'b0, 8'h77);
    do_eoi("R13 done", 1'b0, 8'h00);
    chk("R2 final idle", cpu_irq, 0);
  endtask

  initial begin
    #(8 * 50000);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_empty;
    t_disable;
    t_order;
    t_mask;
    t_level;
    t_directed;
    t_idle_eoi;
    t_legacy;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule